// File: doc/BRIEF.md
# Windowed Product-Term Cluster Router

This block routes groups of product terms to the macrocells of one logic block. The 64 incoming logic terms form 16 clusters of four adjacent terms. A static configuration field per cluster names one target macrocell and carries an enable bit. The block ORs every cluster routed to a macrocell into that macrocell's sum-of-products output.

A macrocell can only reach a small window of nearby clusters: one below its own index and two above it, clipped at both ends of the cluster range. Each cluster drives at most one macrocell, so the 64 terms are shared out and never duplicated. A configuration error flag is raised when an enabled cluster names a macrocell outside its reach. Such a cluster is dropped from every sum.

The two output-enable terms and the asynchronous set and clear terms of the logic block do not pass through this router. The block is purely combinational. Its configuration is expected to be static while it is in use.

Top module: `pt_alloc`

## Requirements
- R1: Cluster k consists of terms pt_i[4k+3:4k]. When that cluster is enabled and legally routed to macrocell m, any high term among those four drives sum_o[m] high.
- R2: Each bit sum_o[m] equals the OR, over all enabled clusters legally routed to m, of their four terms.
- R3: Cluster k may be routed to macrocell m only when m-1 <= k <= m+2, with k and m both in 0..15. This makes macrocell 0 reach clusters 0..2, macrocell 14 reach clusters 13..15, and macrocell 15 reach clusters 14..15. The target of cluster k is clu_tgt_i[4k+3:4k], an unsigned macrocell index.
- R4: A cluster whose enable bit clu_vld_i[k] is 0 affects no sum bit and does not affect cfg_err_o, whatever its target field holds.
- R5: A macrocell that has no enabled, legally routed cluster outputs 0.
- R6: cfg_err_o is 1 exactly when at least one enabled cluster names a macrocell outside its window.
- R7: An enabled cluster that names a macrocell outside its window contributes to no sum bit.
- R8: A cluster reaches at most one macrocell. With a single active cluster, at most one sum bit is high.
- R9: One macrocell can collect all four clusters of its window, which is 16 product terms. For example, macrocell 1 can take clusters 0, 1, 2 and 3 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_i | input | 64 | Logic product terms, four per cluster |
| clu_tgt_i | input | 64 | Per-cluster target macrocell index, 4 bits per cluster |
| clu_vld_i | input | 16 | Per-cluster enable bit |
| sum_o | output | 16 | Sum-of-products per macrocell |
| cfg_err_o | output | 1 | An enabled cluster names an unreachable macrocell |

## Verification
The bench builds the block with its default parameters: 16 clusters of four terms, 16 macrocells, and a window of one cluster below and two above. With these values both clipped ends of the window can be reached, as can the full four-cluster window of the middle macrocells and the exact boundary offsets on each side. Random configurations with offsets from -2 to +1 around each cluster index mix legal and illegal routes. Sparse random term patterns show whether each individual cluster actually reaches its target.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;

   // Cluster k is reachable by macrocell m when m-below <= k <= m+above,
   // with both indices inside their ranges.
   function automatic bit in_window(int m, int k, int below, int above,
                                    int n_mc, int n_clu);
      return (m >= 0) && (m < n_mc) && (k >= 0) && (k < n_clu) &&
             (k >= m - below) && (k <= m + above);
   endfunction

endpackage

// File: rtl/alloc_clu_or.sv
module alloc_clu_or #(
   parameter int TERMS = 4
) (
   input  logic [TERMS-1:0] terms_i,
   output logic             any_o
);
   generate
      if (TERMS == 1) begin : g_single
         assign any_o = terms_i[0];
      end else begin : g_reduce
         assign any_o = |terms_i;
      end
   endgenerate
endmodule

// File: rtl/alloc_route.sv
module alloc_route import pt_alloc_pkg::*; #(
   parameter int NUM_MC    = 16,
   parameter int NUM_CLU   = 16,
   parameter int WIN_BELOW = 1,
   parameter int WIN_ABOVE = 2,
   parameter int CLU_IDX   = 0,
   localparam int TGT_W    = $clog2(NUM_MC)
) (
   input  logic [TGT_W-1:0]  tgt_i,
   input  logic              vld_i,
   output logic [NUM_MC-1:0] grant_o,
   output logic              illegal_o
);
   for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
      if (in_window(m, CLU_IDX, WIN_BELOW, WIN_ABOVE, NUM_MC, NUM_CLU)) begin : g_reach
         assign grant_o[m] = vld_i && (tgt_i == TGT_W'(m));
      end else begin : g_block
         assign grant_o[m] = 1'b0;
      end
   end

   // Any enabled cluster that found no reachable target is misconfigured.
   assign illegal_o = vld_i && !(|grant_o);

   always_comb begin
      // R8
      grant_onehot_chk: assert ($onehot0(grant_o))
         else $error("cluster %0d granted to several macrocells", CLU_IDX);
      // R4
      idle_quiet_chk: assert (vld_i || (grant_o == '0 && !illegal_o))
         else $error("disabled cluster %0d is active", CLU_IDX);
   end
endmodule

// File: rtl/alloc_sum.sv
module alloc_sum import pt_alloc_pkg::*; #(
   parameter int NUM_MC    = 16,
   parameter int NUM_CLU   = 16,
   parameter int WIN_BELOW = 1,
   parameter int WIN_ABOVE = 2,
   parameter int MC_IDX    = 0
) (
   input  logic [NUM_CLU-1:0] hit_i,
   output logic               sum_o
);
   assign sum_o = |hit_i;

   for (genvar k = 0; k < NUM_CLU; k++) begin : g_win
      if (!in_window(MC_IDX, k, WIN_BELOW, WIN_ABOVE, NUM_MC, NUM_CLU)) begin : g_outside
         always_comb begin
            // R3
            outside_window_chk: assert (!hit_i[k])
               else $error("macrocell %0d fed by unreachable cluster %0d", MC_IDX, k);
         end
      end
   end
endmodule

// File: rtl/pt_alloc.sv
module pt_alloc import pt_alloc_pkg::*; #(
   parameter int PT_PER_CLU    = 4,
   parameter int NUM_CLU       = 16,
   parameter int NUM_MC        = 16,
   parameter int WIN_BELOW     = 1,
   parameter int WIN_ABOVE     = 2,
   parameter int MAX_PT_PER_MC = 16,
   localparam int NUM_PT       = PT_PER_CLU * NUM_CLU,
   localparam int TGT_W        = $clog2(NUM_MC),
   localparam int WIN_CLU      = WIN_BELOW + WIN_ABOVE + 1
) (
   input  logic [NUM_PT-1:0]        pt_i,
   input  logic [NUM_CLU*TGT_W-1:0] clu_tgt_i,
   input  logic [NUM_CLU-1:0]       clu_vld_i,
   output logic [NUM_MC-1:0]        sum_o,
   output logic                     cfg_err_o
);
   if (NUM_MC < 2) begin : g_bad_mc
      $error("NUM_MC must be at least 2");
   end
   if (PT_PER_CLU < 1 || NUM_CLU < 1) begin : g_bad_clu
      $error("cluster geometry must be non-empty");
   end
   if (WIN_BELOW < 0 || WIN_ABOVE < 0) begin : g_bad_win
      $error("window extents must be non-negative");
   end
   if (WIN_CLU * PT_PER_CLU > MAX_PT_PER_MC) begin : g_bad_cap
      $error("window exceeds product-term limit per macrocell");
   end

   logic [NUM_CLU-1:0] clu_any;
   logic [NUM_CLU-1:0] clu_bad;
   logic [NUM_CLU-1:0] clu_live;
   logic [NUM_MC-1:0]  grant [NUM_CLU];
   logic [NUM_CLU-1:0] hit   [NUM_MC];

   for (genvar k = 0; k < NUM_CLU; k++) begin : g_clu
      alloc_clu_or #(.TERMS(PT_PER_CLU)) u_or (
         .terms_i (pt_i[k*PT_PER_CLU +: PT_PER_CLU]),
         .any_o   (clu_any[k])
      );
      alloc_route #(
         .NUM_MC(NUM_MC), .NUM_CLU(NUM_CLU),
         .WIN_BELOW(WIN_BELOW), .WIN_ABOVE(WIN_ABOVE), .CLU_IDX(k)
      ) u_route (
         .tgt_i     (clu_tgt_i[k*TGT_W +: TGT_W]),
         .vld_i     (clu_vld_i[k]),
         .grant_o   (grant[k]),
         .illegal_o (clu_bad[k])
      );
      assign clu_live[k] = (|grant[k]) && clu_any[k];
   end

   for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
      for (genvar k = 0; k < NUM_CLU; k++) begin : g_col
         assign hit[m][k] = grant[k][m] && clu_any[k];
      end
      alloc_sum #(
         .NUM_MC(NUM_MC), .NUM_CLU(NUM_CLU),
         .WIN_BELOW(WIN_BELOW), .WIN_ABOVE(WIN_ABOVE), .MC_IDX(m)
      ) u_sum (
         .hit_i (hit[m]),
         .sum_o (sum_o[m])
      );
   end

   assign cfg_err_o = |clu_bad;

   always_comb begin
      // R6
      err_needs_vld_chk: assert (!cfg_err_o || (|clu_vld_i))
         else $error("config error with no enabled cluster");
      // R7
      sum_bounded_chk: assert ($countones(sum_o) <= $countones(clu_live))
         else $error("more active sums than live legal clusters");
      // R5
      no_vld_no_sum_chk: assert ((|clu_vld_i) || sum_o == '0)
         else $error("sum active with every cluster disabled");
   end
endmodule

// File: tb/tb_pt_alloc.sv
module tb_pt_alloc;
   localparam int NC = 16;
   localparam int NM = 16;

   logic        clk = 1'b0;
   logic [63:0] pt;
   logic [63:0] tgt;
   logic [15:0] vld;
   logic [15:0] sum;
   logic        err;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pt_alloc dut (
      .pt_i      (pt),
      .clu_tgt_i (tgt),
      .clu_vld_i (vld),
      .sum_o     (sum),
      .cfg_err_o (err)
   );

   function automatic bit reach(int m, int k);
      return (k <= m + 2) && (m <= k + 1) && m < NM && k < NC;
   endfunction

   function automatic logic [16:0] model(logic [63:0] p, logic [63:0] t, logic [15:0] v);
      logic [15:0] s = '0;
      logic        e = 1'b0;
      for (int k = 0; k < NC; k++) begin
         int m = int'(t[4*k +: 4]);
         if (v[k]) begin
            if (reach(m, k)) s[m] = s[m] | (|p[4*k +: 4]);
            else e = 1'b1;
         end
      end
      return {e, s};
   endfunction

   task automatic apply(logic [63:0] p, logic [63:0] t, logic [15:0] v);
      @(posedge clk);
      pt = p; tgt = t; vld = v;
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [16:0] exp);
      checks++;
      if ({err, sum} !== exp) begin
         errors++;
         $display("FAIL %s actual err=%0b sum=%h expected err=%0b sum=%h",
                  req, err, sum, exp[16], exp[15:0]);
      end
   endtask

   function automatic logic [63:0] set_tgt(logic [63:0] t, int k, int m);
      logic [63:0] r = t;
      r[4*k +: 4] = 4'(m);
      return r;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] t;
      logic [63:0] ident;
      int unused_seed;
      unused_seed = $urandom(32'd2024);
      ident = '0;
      for (int k = 0; k < NC; k++) ident = set_tgt(ident, k, k);

      // R4 R5: all disabled, every term high, stray targets
      apply('1, 64'hFEDC_BA98_7654_3210, 16'h0000);
      chk("R4", 17'h0);
      apply('1, '0, 16'h0000);
      chk("R5", 17'h0);

      // R1: cluster 5 routed to macrocell 5, single term at each edge of the cluster
      apply(64'h1 << 20, ident, 16'h0020);
      chk("R1", {1'b0, 16'h0020});
      apply(64'h1 << 23, ident, 16'h0020);
      chk("R1", {1'b0, 16'h0020});
      apply(64'h1 << 24, ident, 16'h0020);
      chk("R1", 17'h0);

      // R3: boundary offsets at the clipped ends
      apply(64'hF << 8, set_tgt('0, 2, 0), 16'h0004);
      chk("R3", {1'b0, 16'h0001});
      apply(64'hF << 12, set_tgt('0, 3, 0), 16'h0008);
      chk("R7", {1'b1, 16'h0000});
      apply(64'hF << 52, set_tgt('0, 13, 15), 16'h2000);
      chk("R3", {1'b1, 16'h0000});
      apply(64'hF << 56, set_tgt('0, 14, 15), 16'h4000);
      chk("R3", {1'b0, 16'h8000});
      apply(64'hF << 60, set_tgt('0, 15, 13), 16'h8000);
      chk("R3", {1'b0, 16'h2000});
      apply(64'h1, set_tgt('0, 0, 1), 16'h0001);
      chk("R3", {1'b0, 16'h0002});
      apply(64'h1, set_tgt('0, 0, 2), 16'h0001);
      chk("R6", {1'b1, 16'h0000});

      // R9: clusters 0..3 all to macrocell 1, each term alone reaches it
      t = '0;
      for (int k = 0; k < 4; k++) t = set_tgt(t, k, 1);
      for (int b = 0; b < 16; b++) begin
         apply(64'h1 << b, t, 16'h000F);
         chk("R9", {1'b0, 16'h0002});
      end

      // R8: identity routing, one active cluster at a time
      for (int k = 0; k < NC; k++) begin
         apply(64'hF << (4 * k), ident, 16'hFFFF);
         checks++;
         if ($countones(sum) != 1 || sum[k] !== 1'b1) begin
            errors++;
            $display("FAIL R8 actual sum=%h expected one-hot bit %0d", sum, k);
         end
      end

      // R2 R6: constrained random configurations
      for (int i = 0; i < 400; i++) begin
         logic [63:0] p;
         logic [15:0] v;
         t = '0;
         for (int k = 0; k < NC; k++) begin
            int m;
            if ($urandom_range(0, 3) == 0) m = int'($urandom_range(0, 15));
            else m = k + int'($urandom_range(0, 3)) - 2;
            if (m < 0 || m > 15) m = k;
            t = set_tgt(t, k, m);
         end
         v = 16'($urandom);
         if (i % 3 == 0) v = '1;
         p = {$urandom, $urandom};
         if (i % 2 == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
         apply(p, t, v);
         chk((i % 2 == 0) ? "R2" : "R6", model(p, t, v));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule